// File: doc/BRIEF.md
# Serial Vacuum Fluorescent Display Driver Core

This block is the digital front end of a multiplexed vacuum fluorescent display driver. A host controller drives four slow pins: a serial data line, a shift clock, a strobe and a grid-enable line. The block samples them with a faster system clock. On each rising edge of the shift clock it shifts one data bit into a frame register that is 34 bits deep.

While the strobe is high, a hold register follows the frame register. When the strobe goes low, the hold register keeps the last pattern it took. The hold register drives three grid enables and thirty-one anode enables as logic levels. The grid enables pass through a gate that the grid-enable input controls. The anode enables are never gated. Analog drive stages are outside this block.

Top module: `vfd_serial_core`

## Requirements
- R1: Each rising edge of the shift clock, seen after synchronization, shifts exactly one bit from the data line into the frame register. No other input change shifts the register.
- R2: While the strobe is high, the outputs follow the frame register, including bits shifted in during that time. While the strobe is low, the outputs keep the pattern held when the strobe fell.
- R3: The active-high reset, synchronous to the system clock, clears the frame register and the hold register, so every grid and anode output reads 0.
- R4: A held 1 turns the matching output on (output = 1). A held 0 turns it off (output = 0).
- R5: When the grid-enable input is 0, all three grid outputs read 0 whatever is held. When it is 1, each grid output equals its held bit.
- R6: Anode outputs equal their held bits whatever the grid-enable input is.
- R7: In the bit stream, position 1 is the first of the last 34 bits shifted in. Positions 1 to 3 drive gridOut[0] to gridOut[2]. Positions 4 to 34 drive anodeOut[0] to anodeOut[30].
- R8: When more than 34 bits are shifted in before a strobe, the earliest bits are dropped and only the last 34 received are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset, also used as power-on reset |
| serData | input | 1 | Serial data line from the host |
| serClk | input | 1 | Shift clock from the host (asynchronous) |
| serStrobe | input | 1 | Strobe; the hold register is transparent while this is high |
| gridEnable | input | 1 | Gate for the grid outputs |
| gridOut | output | 3 | Grid enables, grid 1 at bit 0 |
| anodeOut | output | 31 | Anode enables, anode 1 at bit 0 |

## Verification
A shift and a transparent load can happen in the same system clock cycle. With the strobe held high, the bench shifts bits one at a time. After each rising edge it checks that the outputs show the new bit at the in-end and every earlier bit one stream position further along. An output that trailed the shift or skipped a bit would fail that check. A grid-enable change can also coincide with a held pattern. The bench toggles the gate after a load and judges it by whether the grid outputs alone are cleared while the anodes stay unchanged.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic gridGate;
    logic dataBit;
  } vfdCtl_t;
endpackage

// File: rtl/vfd_input_sync.sv
module vfd_input_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageReg;

  always_ff @(posedge clk) begin
    if (rst) stageReg[0] <= '0;
    else     stageReg[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stageReg[s] <= '0;
      else     stageReg[s] <= stageReg[s-1];
    end
  end

  assign syncOut = stageReg[STAGES-1];
endmodule

// File: rtl/vfd_ctrl.sv
module vfd_ctrl
  import vfd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    syncData,
  input  logic    syncClk,
  input  logic    syncStrobe,
  input  logic    syncGridEn,
  output vfdCtl_t ctl
);
  logic prevClk;

  always_ff @(posedge clk) begin
    if (rst) prevClk <= 1'b0;
    else     prevClk <= syncClk;
  end

  always_comb begin
    ctl.shiftEn  = syncClk & ~prevClk;
    ctl.loadEn   = syncStrobe;
    ctl.gridGate = syncGridEn;
    ctl.dataBit  = syncData;
  end

  // R1
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> !ctl.shiftEn);
endmodule

// File: rtl/vfd_datapath.sv
module vfd_datapath
  import vfd_pkg::*;
#(
  parameter int GRID_COUNT  = 3,
  parameter int ANODE_COUNT = 31
) (
  input  logic                   clk,
  input  logic                   rst,
  input  vfdCtl_t                ctl,
  output logic [GRID_COUNT-1:0]  gridOut,
  output logic [ANODE_COUNT-1:0] anodeOut
);
  localparam int TOTAL = GRID_COUNT + ANODE_COUNT;

  logic [TOTAL-1:0] frameReg;
  logic [TOTAL-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst)              frameReg <= '0;
    else if (ctl.shiftEn) frameReg <= {frameReg[TOTAL-2:0], ctl.dataBit};
  end

  always_ff @(posedge clk) begin
    if (rst)             holdReg <= '0;
    else if (ctl.loadEn) holdReg <= frameReg;
  end

  for (genvar g = 0; g < GRID_COUNT; g++) begin : g_grid
    assign gridOut[g] = holdReg[TOTAL-1-g] & ctl.gridGate;
  end

  for (genvar a = 0; a < ANODE_COUNT; a++) begin : g_anode
    assign anodeOut[a] = holdReg[ANODE_COUNT-1-a];
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> frameReg[0] == $past(ctl.dataBit));

  // R1
  no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.shiftEn |=> $stable(frameReg));

  // R8
  far_end_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> frameReg[TOTAL-1] == $past(frameReg[TOTAL-2]));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadEn |=> $stable(holdReg));

  // R6
  anode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadEn |=> $stable(anodeOut));

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (frameReg == '0 && holdReg == '0));
endmodule

// File: rtl/vfd_serial_core.sv
module vfd_serial_core
  import vfd_pkg::*;
#(
  parameter int GRID_COUNT  = 3,
  parameter int ANODE_COUNT = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   serData,
  input  logic                   serClk,
  input  logic                   serStrobe,
  input  logic                   gridEnable,
  output logic [GRID_COUNT-1:0]  gridOut,
  output logic [ANODE_COUNT-1:0] anodeOut
);
  logic [3:0] syncPins;
  vfdCtl_t    ctl;

  vfd_input_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({gridEnable, serStrobe, serClk, serData}),
    .syncOut (syncPins)
  );

  vfd_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .syncData   (syncPins[0]),
    .syncClk    (syncPins[1]),
    .syncStrobe (syncPins[2]),
    .syncGridEn (syncPins[3]),
    .ctl        (ctl)
  );

  vfd_datapath #(.GRID_COUNT(GRID_COUNT), .ANODE_COUNT(ANODE_COUNT)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .gridOut  (gridOut),
    .anodeOut (anodeOut)
  );
endmodule

// File: tb/test_vfd_serial_core.sv
module test_vfd_serial_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serData = 1'b0, serClk = 1'b0, serStrobe = 1'b0, gridEnable = 1'b0;
  logic [2:0]  gridOut;
  logic [30:0] anodeOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit stream [0:4095];
  int nBits = 0;
  logic [33:0] heldExp;

  always #2.5 clk = ~clk;

  vfd_serial_core i_vfd_serial_core (
    .clk(clk), .rst(rst), .serData(serData), .serClk(serClk),
    .serStrobe(serStrobe), .gridEnable(gridEnable),
    .gridOut(gridOut), .anodeOut(anodeOut)
  );

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stream position p (1..34) among the last 34 bits; zero if not yet shifted
  function automatic bit posBit(input int p);
    int idx = nBits - 34 + p - 1;
    if (idx < 0) return 1'b0;
    return stream[idx];
  endfunction

  // expected {grids[2:0], anodes[30:0]} before gating
  function automatic logic [33:0] frameExp();
    logic [33:0] e;
    for (int g = 1; g <= 3; g++) e[31+g-1] = posBit(g);
    for (int a = 1; a <= 31; a++) e[a-1] = posBit(a+3);
    return e;
  endfunction

  task automatic checkOut(input string req, input logic [33:0] expv, input bit gEn);
    logic [2:0] eg;
    eg = gEn ? expv[33:31] : 3'b000;
    compared++;
    if (gridOut !== eg || anodeOut !== expv[30:0]) begin
      mismatched++;
      $display("FAIL %s: grid=%b anode=%b expected grid=%b anode=%b",
               req, gridOut, anodeOut, eg, expv[30:0]);
    end
  endtask

  task automatic sendBit(input bit b);
    serData = b;
    waitCyc(4);
    serClk = 1'b1;
    stream[nBits] = b;
    nBits++;
    waitCyc(8);
    serClk = 1'b0;
    waitCyc(4);
  endtask

  task automatic pulseStrobe();
    serStrobe = 1'b1;
    waitCyc(8);
    serStrobe = 1'b0;
    waitCyc(8);
    heldExp = frameExp();
  endtask

  task automatic doReset();
    rst = 1'b1;
    waitCyc(4);
    rst = 1'b0;
    nBits = 0;
    heldExp = '0;
    waitCyc(2);
  endtask

  initial begin
    doReset();
    gridEnable = 1'b1;
    waitCyc(6);
    // R3: reset state, all off
    checkOut("R3 reset", 34'h0, 1'b1);
    pulseStrobe();
    checkOut("R3 cleared frame", 34'h0, 1'b1);

    // R7 R4: walking one across every stream position
    for (int p = 1; p <= 34; p++) begin
      for (int k = 1; k <= 34; k++) sendBit(k == p);
      pulseStrobe();
      checkOut("R7 walking one", heldExp, 1'b1);
    end

    // R4: walking zero on an all-ones frame
    for (int p = 1; p <= 34; p += 3) begin
      for (int k = 1; k <= 34; k++) sendBit(k != p);
      pulseStrobe();
      checkOut("R4 walking zero", heldExp, 1'b1);
    end

    // R5 R6: grid gate on an all-ones pattern, then on a mixed pattern
    for (int k = 1; k <= 34; k++) sendBit(1'b1);
    pulseStrobe();
    gridEnable = 1'b0;
    waitCyc(6);
    checkOut("R5 gate off", heldExp, 1'b0);
    checkOut("R6 anodes ungated", heldExp, 1'b0);
    gridEnable = 1'b1;
    waitCyc(6);
    checkOut("R5 gate on", heldExp, 1'b1);
    for (int k = 1; k <= 34; k++) sendBit(((k * 7) % 3) == 1);
    pulseStrobe();
    gridEnable = 1'b0;
    waitCyc(6);
    checkOut("R5 R6 mixed gate off", heldExp, 1'b0);
    gridEnable = 1'b1;
    waitCyc(6);

    // R2: hold while the strobe is low
    for (int k = 1; k <= 5; k++) begin
      sendBit(k[0]);
      checkOut("R2 held while strobe low", heldExp, 1'b1);
    end

    // R2 R1: transparent while the strobe is high, shift and load together
    serStrobe = 1'b1;
    waitCyc(8);
    checkOut("R2 transparent entry", frameExp(), 1'b1);
    for (int k = 0; k < 40; k++) begin
      sendBit(((k * 5) % 7) < 3);
      checkOut("R2 R1 transparent shift", frameExp(), 1'b1);
    end
    serStrobe = 1'b0;
    waitCyc(8);
    heldExp = frameExp();
    for (int k = 0; k < 3; k++) sendBit(1'b1);
    checkOut("R2 hold after strobe fall", heldExp, 1'b1);

    // R1: strobe and data toggles without a shift clock change nothing
    serData = 1'b1;
    waitCyc(6);
    serData = 1'b0;
    waitCyc(6);
    pulseStrobe();
    checkOut("R1 no spurious shift", heldExp, 1'b1);

    // R8: overflow, 50 bits before the strobe
    for (int k = 0; k < 50; k++) sendBit((k % 4) == 0 || k > 45);
    pulseStrobe();
    checkOut("R8 last 34 kept", heldExp, 1'b1);

    // R3: reset in mid-stream clears frame and hold
    for (int k = 0; k < 10; k++) sendBit(1'b1);
    doReset();
    waitCyc(4);
    checkOut("R3 mid-run reset", 34'h0, 1'b1);
    pulseStrobe();
    checkOut("R3 frame cleared by reset", 34'h0, 1'b1);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule